// File: doc/BRIEF.md
# SEC-DED Codec for 16-bit Memory Words

This block sits between a memory controller and the storage array. Each stored word is 16 data bits plus 6 check bits. On a write, the block registers the data and either a check field it generates itself or a raw check value supplied by the host. On a read, it takes the stored 22-bit word and computes a Hamming syndrome and an overall parity. It returns data with any single flipped bit repaired, and it raises a one-cycle status pulse. One pulse marks a repaired word. The other marks a word that cannot be repaired.

A clean word comes back two cycles after the request. A word that needs repair spends one extra cycle in a dedicated fix stage. A read issued in the cycle right after such a word is not accepted. A diagnostic input turns checking off for the reads it accompanies, so raw data returns with no status. The raw stored check bits always come back next to the data, so a host can inspect the check field directly.

Top module: `ecc_word_codec`

## Requirements
- R1: A write request (`wrReq`) presented in cycle c makes `memWrEn` high in cycle c+1, carrying `memWrData` equal to the data and `memWrCheck` equal to the generated check field. The codeword is numbered in positions 1 to 21. Check bit k (k = 0..4) sits at position 2^k. The data bits fill the remaining positions in ascending order, so data bit 0 is at position 3 and data bit 15 is at position 21. Check bit k is the XOR of the data bits whose position has bit k set. Check bit 5 makes the XOR of all 22 bits equal to zero.
- R2: A read (`rdReq`) of a word with zero syndrome and correct overall parity gives `rdDone` high for one cycle in c+2. In that cycle `rdOut` equals the stored data, and neither status pulse is raised.
- R3: A read whose syndrome names a data position and whose overall parity is wrong returns that data bit inverted. It raises `corrErr` together with `rdDone`, and both arrive in cycle c+3 instead of c+2.
- R4: A read with wrong overall parity whose syndrome is zero or a power of two (a flipped check bit) returns the stored data unchanged. It raises `corrErr` with `rdDone` in cycle c+3.
- R5: A read with a nonzero syndrome and correct overall parity returns the stored data unchanged. It raises `uncorrErr` with `rdDone` in cycle c+2.
- R6: A read with wrong overall parity and a syndrome above 21 is treated as uncorrectable. The data is unchanged, and `uncorrErr` is raised with `rdDone` in cycle c+2.
- R7: A read issued with `diagDisable` high returns the stored data unchanged in cycle c+2, with no status pulse, whatever the word holds.
- R8: A write issued with `diagCheckWrite` high puts `rawCheckIn` on `memWrCheck` in place of the generated field.
- R9: On every `rdDone`, `rawCheckOut` equals the 6 check bits exactly as they were read, including after a repair.
- R10: A read request in the cycle right after a read that needs repair produces no `rdDone`. Otherwise a read can be accepted in every cycle, and results come back in request order.
- R11: While `rstN` is low, `rdDone`, `corrErr`, `uncorrErr`, `memWrEn`, `rdOut` and `rawCheckOut` are all zero.
- R12: `corrErr` and `uncorrErr` never rise together, never rise without `rdDone`, and `rdDone` never rises without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrReq | input | 1 | Write request |
| wrData | input | 16 | Data to store |
| diagCheckWrite | input | 1 | Store rawCheckIn instead of generated check bits |
| rawCheckIn | input | 6 | Host-supplied check field |
| memWrEn | output | 1 | Write strobe toward the array |
| memWrData | output | 16 | Data toward the array |
| memWrCheck | output | 6 | Check field toward the array |
| rdReq | input | 1 | Read request, word valid on rdData/rdCheck |
| rdData | input | 16 | Stored data from the array |
| rdCheck | input | 6 | Stored check bits from the array |
| diagDisable | input | 1 | Turns checking off for this read |
| rdDone | output | 1 | Read result valid, one cycle |
| rdOut | output | 16 | Returned (repaired) data |
| rawCheckOut | output | 6 | Stored check bits as read |
| corrErr | output | 1 | A single error was repaired |
| uncorrErr | output | 1 | Uncorrectable error seen |

## Verification
The assertions watch the status pulses on every cycle: they stay exclusive and tied to `rdDone`, a repaired read is always followed by one empty cycle and then a `corrErr` result, a double-error read raises `uncorrErr`, and a diagnostic read stays silent. They also check that only one result source is active at a time and that the raw check write takes effect. The corrected data values, the split between data-bit and check-bit errors, the handling of syndromes above 21, and the dropping of a request behind a repaired word depend on the stored contents, so only the bench's scenarios show them. Those scenarios flip every single bit, chosen pairs and triples, and issue back-to-back reads.

// File: rtl/ecc_word_pkg.sv
package ecc_word_pkg;
  localparam int DataW  = 16;
  localparam int HamW   = 5;
  localparam int CheckW = HamW + 1;
  localparam int MaxPos = DataW + HamW;

  typedef enum logic [1:0] {ClsClean, ClsSingle, ClsDouble} eccClass_t;

  typedef struct packed {
    logic loadIn;
    logic loadFix;
    logic outFromIn;
    logic outFromFix;
  } eccStrobe_t;

  // Codeword position of data bit idx: the idx-th position that is not a power of two.
  function automatic int dataPosOf(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= MaxPos; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [CheckW-1:0] genCheck(input logic [DataW-1:0] d);
    logic [CheckW-1:0] c;
    c = '0;
    for (int i = 0; i < DataW; i++) begin
      for (int k = 0; k < HamW; k++) begin
        if (((dataPosOf(i) >> k) & 1) != 0) c[k] = c[k] ^ d[i];
      end
    end
    c[HamW] = ^{d, c[HamW-1:0]};
    return c;
  endfunction
endpackage

// File: rtl/ecc_word_datapath.sv
module ecc_word_datapath
  import ecc_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobe,
  input  logic              wrReq,
  input  logic [DataW-1:0]  wrData,
  input  logic              diagCheckWrite,
  input  logic [CheckW-1:0] rawCheckIn,
  input  logic [DataW-1:0]  rdData,
  input  logic [CheckW-1:0] rdCheck,
  input  logic              diagDisable,
  output eccClass_t         inClass,
  output logic              memWrEn,
  output logic [DataW-1:0]  memWrData,
  output logic [CheckW-1:0] memWrCheck,
  output logic [DataW-1:0]  rdOut,
  output logic [CheckW-1:0] rawCheckOut
);
  logic [DataW-1:0]  inData;
  logic [CheckW-1:0] inCheck;
  logic              inDiag;
  logic [CheckW-1:0] regenCheck;
  logic [HamW-1:0]   inSyn;
  logic              inParErr;
  logic [DataW-1:0]  fixMask;
  logic [DataW-1:0]  fixData;
  logic [CheckW-1:0] fixCheck;

  // write path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn    <= 1'b0;
      memWrData  <= '0;
      memWrCheck <= '0;
    end else begin
      memWrEn <= wrReq;
      if (wrReq) begin
        memWrData  <= wrData;
        memWrCheck <= diagCheckWrite ? rawCheckIn : genCheck(wrData);
      end
    end
  end

  // input stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inData  <= '0;
      inCheck <= '0;
      inDiag  <= 1'b0;
    end else if (strobe.loadIn) begin
      inData  <= rdData;
      inCheck <= rdCheck;
      inDiag  <= diagDisable;
    end
  end

  assign regenCheck = genCheck(inData);
  assign inSyn      = regenCheck[HamW-1:0] ^ inCheck[HamW-1:0];
  assign inParErr   = ^{inData, inCheck};

  always_comb begin
    if (inDiag || (!inParErr && (inSyn == '0)))       inClass = ClsClean;
    else if (inParErr && (inSyn <= HamW'(MaxPos)))    inClass = ClsSingle;
    else                                              inClass = ClsDouble;
  end

  for (genvar i = 0; i < DataW; i++) begin : g_fix
    localparam int Pos = dataPosOf(i);
    assign fixMask[i] = (inSyn == HamW'(Pos));
  end

  // fix stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixData  <= '0;
      fixCheck <= '0;
    end else if (strobe.loadFix) begin
      fixData  <= inData ^ fixMask;
      fixCheck <= inCheck;
    end
  end

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOut       <= '0;
      rawCheckOut <= '0;
    end else if (strobe.outFromFix) begin
      rdOut       <= fixData;
      rawCheckOut <= fixCheck;
    end else if (strobe.outFromIn) begin
      rdOut       <= inData;
      rawCheckOut <= inCheck;
    end
  end
endmodule

// File: rtl/ecc_word_control.sv
module ecc_word_control
  import ecc_word_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  eccClass_t  inClass,
  output eccStrobe_t strobe,
  output logic       rdDone,
  output logic       corrErr,
  output logic       uncorrErr
);
  logic inValid;
  logic fixValid;

  always_comb begin
    strobe.outFromIn  = inValid && (inClass != ClsSingle);
    strobe.loadFix    = inValid && (inClass == ClsSingle);
    strobe.loadIn     = rdReq && !strobe.loadFix;
    strobe.outFromFix = fixValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inValid   <= 1'b0;
      fixValid  <= 1'b0;
      rdDone    <= 1'b0;
      corrErr   <= 1'b0;
      uncorrErr <= 1'b0;
    end else begin
      inValid   <= strobe.loadIn;
      fixValid  <= strobe.loadFix;
      rdDone    <= strobe.outFromIn || strobe.outFromFix;
      corrErr   <= strobe.outFromFix;
      uncorrErr <= strobe.outFromIn && (inClass == ClsDouble);
    end
  end
endmodule

// File: rtl/ecc_word_codec.sv
module ecc_word_codec
  import ecc_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [DataW-1:0]  wrData,
  input  logic              diagCheckWrite,
  input  logic [CheckW-1:0] rawCheckIn,
  output logic              memWrEn,
  output logic [DataW-1:0]  memWrData,
  output logic [CheckW-1:0] memWrCheck,
  input  logic              rdReq,
  input  logic [DataW-1:0]  rdData,
  input  logic [CheckW-1:0] rdCheck,
  input  logic              diagDisable,
  output logic              rdDone,
  output logic [DataW-1:0]  rdOut,
  output logic [CheckW-1:0] rawCheckOut,
  output logic              corrErr,
  output logic              uncorrErr
);
  eccStrobe_t strobe;
  eccClass_t  inClass;

  ecc_word_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdReq     (rdReq),
    .inClass   (inClass),
    .strobe    (strobe),
    .rdDone    (rdDone),
    .corrErr   (corrErr),
    .uncorrErr (uncorrErr)
  );

  ecc_word_datapath u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .wrReq          (wrReq),
    .wrData         (wrData),
    .diagCheckWrite (diagCheckWrite),
    .rawCheckIn     (rawCheckIn),
    .rdData         (rdData),
    .rdCheck        (rdCheck),
    .diagDisable    (diagDisable),
    .inClass        (inClass),
    .memWrEn        (memWrEn),
    .memWrData      (memWrData),
    .memWrCheck     (memWrCheck),
    .rdOut          (rdOut),
    .rawCheckOut    (rawCheckOut)
  );
endmodule

// File: rtl/ecc_word_checker.sv
module ecc_word_checker
  import ecc_word_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic              diagCheckWrite,
  input logic [CheckW-1:0] rawCheckIn,
  input logic              memWrEn,
  input logic [CheckW-1:0] memWrCheck,
  input logic              diagDisable,
  input logic              rdDone,
  input logic              corrErr,
  input logic              uncorrErr,
  input eccStrobe_t        strobe,
  input eccClass_t         inClass
);
  p_write_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> memWrEn);

  p_clean_progress_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadIn |=> (strobe.outFromIn || strobe.loadFix));

  p_fix_extra_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFix |=> (!rdDone ##1 (rdDone && corrErr)));

  p_double_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outFromIn && inClass == ClsDouble) |=> (rdDone && uncorrErr));

  p_diag_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadIn && diagDisable) |=> ##1 (rdDone && !corrErr && !uncorrErr));

  p_raw_check_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && diagCheckWrite) |=> (memWrCheck == $past(rawCheckIn)));

  p_single_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.outFromIn, strobe.outFromFix}));

  p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(corrErr && uncorrErr));

  p_flag_needs_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    (corrErr || uncorrErr) |-> rdDone);
endmodule

bind ecc_word_codec ecc_word_checker u_chk (.*);

// File: tb/sim_ecc_word_codec.sv
`timescale 1ns/1ps
module sim_ecc_word_codec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrReq = 1'b0;
  logic [15:0] wrData = '0;
  logic        diagCheckWrite = 1'b0;
  logic [5:0]  rawCheckIn = '0;
  logic        memWrEn;
  logic [15:0] memWrData;
  logic [5:0]  memWrCheck;
  logic        rdReq = 1'b0;
  logic [15:0] rdData = '0;
  logic [5:0]  rdCheck = '0;
  logic        diagDisable = 1'b0;
  logic        rdDone;
  logic [15:0] rdOut;
  logic [5:0]  rawCheckOut;
  logic        corrErr;
  logic        uncorrErr;

  int checks = 0;
  int errors = 0;
  int edgeN = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc_word_codec u0 (.*);

  typedef struct {
    int          due;
    logic [15:0] data;
    logic [5:0]  chk;
    bit          corr;
    bit          unc;
    string       tag;
  } expRd_t;
  expRd_t expQ[$];

  bit          prevFix = 0;
  bit          expWrEn = 0;
  logic [15:0] expWrData = '0;
  logic [5:0]  expWrChk = '0;
  string       expWrTag = "R1";

  function automatic int posOf(input int i);
    int p;
    int n;
    p = 2;
    n = -1;
    while (n < i) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic logic [5:0] refCheck(input logic [15:0] d);
    int syn;
    logic [5:0] c;
    syn = 0;
    for (int i = 0; i < 16; i++) if (d[i]) syn = syn ^ posOf(i);
    c[4:0] = syn[4:0];
    c[5] = (^d) ^ (^c[4:0]);
    return c;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at edge %0d", tag, what, act, exp, edgeN);
    end
  endtask

  // behavioural reference: runs on every sampling edge
  always @(posedge clk) begin
    edgeN++;
    if (!rstN) begin
      prevFix = 0;
      expWrEn = 0;
      expQ.delete();
    end else begin
      bit nextFix;
      expWrEn = wrReq;
      if (wrReq) begin
        expWrData = wrData;
        expWrChk  = diagCheckWrite ? rawCheckIn : refCheck(wrData);
        expWrTag  = diagCheckWrite ? "R8" : "R1";
      end
      nextFix = 0;
      if (rdReq && !prevFix) begin
        expRd_t e;
        int syn;
        bit par;
        syn = 0;
        for (int i = 0; i < 16; i++) if (rdData[i]) syn = syn ^ posOf(i);
        for (int k = 0; k < 5; k++) if (rdCheck[k]) syn = syn ^ (1 << k);
        par = ^{rdData, rdCheck};
        e.data = rdData;
        e.chk  = rdCheck;
        e.corr = 0;
        e.unc  = 0;
        e.due  = edgeN + 1;
        if (diagDisable) e.tag = "R7";
        else if (syn == 0 && !par) e.tag = "R2";
        else if (par && syn <= 21) begin
          bit hit;
          hit = 0;
          for (int i = 0; i < 16; i++) if (posOf(i) == syn) begin
            e.data[i] = ~e.data[i];
            hit = 1;
          end
          e.tag  = hit ? "R3" : "R4";
          e.corr = 1;
          e.due  = edgeN + 2;
          nextFix = 1;
        end else if (par) begin
          e.tag = "R6";
          e.unc = 1;
        end else begin
          e.tag = "R5";
          e.unc = 1;
        end
        expQ.push_back(e);
      end
      prevFix = nextFix;
    end
  end

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1", "memWrEn", int'(memWrEn), int'(expWrEn));
      if (expWrEn) begin
        check("R1", "memWrData", int'(memWrData), int'(expWrData));
        check(expWrTag, "memWrCheck", int'(memWrCheck), int'(expWrChk));
      end
      if (expQ.size() > 0 && expQ[0].due == edgeN) begin
        expRd_t e;
        e = expQ.pop_front();
        check(e.tag, "rdDone", int'(rdDone), 1);
        check(e.tag, "rdOut", int'(rdOut), int'(e.data));
        check("R9", "rawCheckOut", int'(rawCheckOut), int'(e.chk));
        check(e.tag, "corrErr", int'(corrErr), int'(e.corr));
        check(e.tag, "uncorrErr", int'(uncorrErr), int'(e.unc));
      end else begin
        check("R12 R10", "rdDone idle", int'(rdDone), 0);
        check("R12", "corrErr idle", int'(corrErr), 0);
        check("R12", "uncorrErr idle", int'(uncorrErr), 0);
      end
    end
  end

  task automatic issueWrite(input logic [15:0] d, input bit diag, input logic [5:0] raw);
    wrReq = 1'b1;
    wrData = d;
    diagCheckWrite = diag;
    rawCheckIn = raw;
    @(negedge clk);
    wrReq = 1'b0;
    diagCheckWrite = 1'b0;
  endtask

  task automatic issueRead(input logic [15:0] d, input int fa, input int fb, input int fc, input bit diag);
    logic [21:0] cw;
    cw = {refCheck(d), d};
    if (fa >= 0) cw[fa] = ~cw[fa];
    if (fb >= 0) cw[fb] = ~cw[fb];
    if (fc >= 0) cw[fc] = ~cw[fc];
    rdReq = 1'b1;
    rdData = cw[15:0];
    rdCheck = cw[21:16];
    diagDisable = diag;
    @(negedge clk);
    rdReq = 1'b0;
    diagDisable = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "rdDone reset", int'(rdDone), 0);
    check("R11", "corrErr reset", int'(corrErr), 0);
    check("R11", "uncorrErr reset", int'(uncorrErr), 0);
    check("R11", "memWrEn reset", int'(memWrEn), 0);
    check("R11", "rdOut reset", int'(rdOut), 0);
    check("R11", "rawCheckOut reset", int'(rawCheckOut), 0);
    rstN = 1'b1;
    idle(2);

    // R1 and R8: write path
    issueWrite(16'h0000, 0, 6'h00);
    issueWrite(16'hFFFF, 0, 6'h00);
    issueWrite(16'hA5C3, 0, 6'h00);
    idle(1);
    issueWrite(16'h1234, 1, 6'h2A);
    issueWrite(16'h8001, 1, 6'h15);
    issueWrite(16'h8001, 0, 6'h3F);
    idle(3);

    // R2: clean reads
    issueRead(16'h0000, -1, -1, -1, 0); idle(3);
    issueRead(16'hFFFF, -1, -1, -1, 0); idle(3);
    issueRead(16'hA5C3, -1, -1, -1, 0); idle(3);

    // R3 and R4: every single flip, two data patterns
    for (int b = 0; b < 22; b++) begin
      issueRead(16'hA5C3, b, -1, -1, 0); idle(3);
      issueRead(16'h0000, b, -1, -1, 0); idle(3);
    end

    // R5: doubles
    issueRead(16'h1234, 0, 1, -1, 0); idle(3);
    issueRead(16'h1234, 3, 17, -1, 0); idle(3);
    issueRead(16'hFFFF, 16, 21, -1, 0); idle(3);
    issueRead(16'h8001, 5, 20, -1, 0); idle(3);

    // R6: triples with syndrome above 21 and wrong parity
    issueRead(16'h5A5A, 3, 19, 20, 0); idle(3);
    issueRead(16'h0F0F, 15, 5, 21, 0); idle(3);

    // R7: diagnostic reads
    issueRead(16'h00FF, 4, -1, -1, 1); idle(3);
    issueRead(16'h00FF, 2, 9, -1, 1); idle(3);
    issueRead(16'hC3C3, -1, -1, -1, 1); idle(3);

    // R10: back-to-back reads and dropping behind a repair
    issueRead(16'h1111, -1, -1, -1, 0);
    issueRead(16'h2222, -1, -1, -1, 0);
    issueRead(16'h3333, 7, -1, -1, 0);
    issueRead(16'h4444, -1, -1, -1, 0);
    issueRead(16'h5555, -1, -1, -1, 0);
    issueRead(16'h6666, 18, -1, -1, 0);
    issueRead(16'h7777, 2, -1, -1, 0);
    issueRead(16'h8888, 0, 1, -1, 0);
    idle(6);

    check("R10", "pending results", expQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule